// File: doc/BRIEF.md
# DRAM Refresh Cycle Decoder

This block sits on the device side of an asynchronous DRAM and watches the row and column strobes through a sampling clock that runs much faster than the strobes. Every time the row strobe goes low and then returns high, it sorts that period into one of four kinds. A normal access opens a row and then strobes a column. A row-strobe-only refresh opens a row and never strobes a column. An internally addressed refresh has the column strobe already low when the row strobe falls. A hidden refresh is the same internally addressed refresh, but it follows a read while the column strobe is still held low.

The block picks the row to activate. For normal accesses and row-strobe-only refreshes the row comes from the address pins. For the two internally addressed refresh kinds it comes from an internal refresh counter, and that counter moves on only after those two kinds. The block also forms the column address, which follows the pins while the row strobe is low until the column strobe latches it. It drives the enable for the data output drivers and a flag that says earlier read data must stay on the outputs. A parameter selects either the 4096-row organisation or the 2048-row organisation.

Top module: `dram_refresh_decoder`

## Requirements
- R1: While the row strobe is low after reset, the block classifies the period. If the column strobe was high at the row-strobe fall and then fell before the row strobe rose, the type is 2'b00 (normal access). If the column strobe stayed high for the whole period, the type is 2'b01 (row-strobe-only refresh).
- R2: If the column strobe is low at the sample where the row strobe falls, and no read data is being held, the type is 2'b10 (internally addressed refresh). The write-enable and output-enable inputs have no effect on this cycle.
- R3: If the row strobe falls while read data is held (the column strobe low since a read), the type is 2'b11 (hidden refresh).
- R4: For types 2'b00 and 2'b01, `row_addr` takes the address pins sampled at the row-strobe fall, masked to 12 bits (4096 rows) or 11 bits (2048 rows).
- R5: For types 2'b10 and 2'b11, `row_addr` takes the internal refresh counter value.
- R6: The counter starts at 0 after reset. It rises by one after each completed 2'b10 or 2'b11 cycle and wraps to 0 after row 4095 (or 2047). Types 2'b00 and 2'b01 leave it unchanged.
- R7: During types 2'b01 and 2'b10, `dq_oe` stays low whatever the write-enable and output-enable inputs do.
- R8: During a normal access, `dq_oe` is high only when write-enable was high at the column-strobe fall (a read), the column strobe is low, and output-enable is low. A write never drives.
- R9: A read access that ends with the column strobe still low sets `hold_data`. `hold_data` and `dq_oe` stay high, including through hidden refreshes, until the column strobe is sampled high, and then both clear.
- R10: `col_addr` is 0 while the row strobe is high. While the row strobe is low and the column strobe is high it follows the address pins combinationally. After the column strobe falls it holds the last pin value sampled with the column strobe high. It is masked to 10 bits (4096-row) or 11 bits (2048-row).
- R11: `cls_pulse` is high for exactly one cycle, in the cycle after the sample that first sees the row strobe high again. `cls_type` is valid with it.
- R12: Reset clears `cls_pulse`, `row_act`, `dq_oe`, `hold_data` and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed address pins |
| row_addr | output | 12 | Row chosen at the last row-strobe fall |
| row_act | output | 1 | High while a row-strobe-low period is active |
| col_addr | output | 12 | Column address, transparent then latched |
| dq_oe | output | 1 | Enable for the data output drivers |
| hold_data | output | 1 | Previous read data must stay driven |
| cls_pulse | output | 1 | One-cycle pulse per classified period |
| cls_type | output | 2 | Type of the classified period |

## Verification
The in-module assertions check several rules on every cycle. The outputs must stay off during row-strobe-only and internally addressed refreshes. The counter must stay in range, and normal or row-strobe-only periods must not change it. The classification pulse must last one cycle. The hold flag must follow the column strobe, and externally addressed rows must come from the pins. Only the bench's strobe sequences can show that each sequence gets the right type code, that the counter values come out in order through the row output, and that the counter wraps after the last row. The same applies to the hidden-refresh handover after a read and the latching of the column address.

// File: rtl/dram_refresh_decoder.sv
module dram_refresh_decoder #(
  parameter bit FOUR_K = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic        oe_n,
  input  logic [11:0] addr,
  output logic [11:0] row_addr,
  output logic        row_act,
  output logic [11:0] col_addr,
  output logic        dq_oe,
  output logic        hold_data,
  output logic        cls_pulse,
  output logic [1:0]  cls_type
);
  localparam int          ROWS     = FOUR_K ? 4096 : 2048;
  localparam int          COL_W    = FOUR_K ? 10 : 11;
  localparam logic [11:0] ROW_MASK = 12'(ROWS - 1);
  localparam logic [11:0] COL_MASK = 12'((1 << COL_W) - 1);
  localparam logic [11:0] LAST_ROW = 12'(ROWS - 1);

  logic        ras_q, cas_q;
  logic        self_adr, hidden_q, acc_seen, is_read;
  logic [11:0] cnt, col_lat;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      row_act   <= 1'b0;
      self_adr  <= 1'b0;
      hidden_q  <= 1'b0;
      acc_seen  <= 1'b0;
      is_read   <= 1'b0;
      hold_data <= 1'b0;
      cnt       <= '0;
      row_addr  <= '0;
      col_lat   <= '0;
      cls_pulse <= 1'b0;
      cls_type  <= 2'b00;
    end else begin
      ras_q     <= ras_n;
      cas_q     <= cas_n;
      cls_pulse <= 1'b0;
      if (cas_n) begin
        col_lat   <= addr & COL_MASK;
        hold_data <= 1'b0;
      end
      if (ras_fall) begin
        row_act  <= 1'b1;
        self_adr <= ~cas_n;
        hidden_q <= ~cas_n & hold_data;
        acc_seen <= 1'b0;
        is_read  <= 1'b0;
        row_addr <= cas_n ? (addr & ROW_MASK) : cnt;
      end else if (cas_fall && row_act && !self_adr && !ras_n) begin
        acc_seen <= 1'b1;
        is_read  <= we_n;
      end
      if (ras_rise && row_act) begin
        row_act   <= 1'b0;
        cls_pulse <= 1'b1;
        if (self_adr) begin
          cls_type <= hidden_q ? 2'b11 : 2'b10;
          cnt      <= (cnt == LAST_ROW) ? '0 : cnt + 12'd1;
        end else begin
          cls_type <= acc_seen ? 2'b00 : 2'b01;
          if (acc_seen && is_read && !cas_n) hold_data <= 1'b1;
        end
      end
    end
  end

  assign col_addr = ras_n ? '0 : (cas_n ? (addr & COL_MASK) : col_lat);
  assign dq_oe    = hold_data | (row_act & acc_seen & is_read & ~cas_n & ~oe_n);

  AST_CBR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && self_adr && !hidden_q) |-> !dq_oe); // R7
  AST_RONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (row_act && !self_adr && !acc_seen && !hold_data) |-> !dq_oe); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_ROW); // R6
  AST_CNT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && row_act && !self_adr) |=> $stable(cnt)); // R6
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    cls_pulse |=> !cls_pulse); // R11
  AST_HOLD_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_data) |-> !$past(cas_n)); // R9
  AST_ROW_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_n) |=> row_addr == ($past(addr) & ROW_MASK)); // R4
endmodule

// File: tb/dram_refresh_decoder_bench.sv
module dram_refresh_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [11:0] row_addr, col_addr;
  logic        row_act, dq_oe, hold_data, cls_pulse;
  logic [1:0]  cls_type;

  dram_refresh_decoder u_dram_refresh_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .row_addr(row_addr), .row_act(row_act),
    .col_addr(col_addr), .dq_oe(dq_oe), .hold_data(hold_data),
    .cls_pulse(cls_pulse), .cls_type(cls_type));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit ended = 0;
  logic [13:0] exp_q[$];
  int model_cnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic expect_cls(input logic [1:0] t, input logic [11:0] r);
    exp_q.push_back({t, r});
  endtask

  always @(negedge clk) begin
    if (rst_n && cls_pulse) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected pulse", {cls_type, row_addr}, 0);
      else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        check(cls_type == e[13:12], "R1/R2/R3 type", cls_type, e[13:12]);
        check(row_addr == e[11:0], "R4/R5 row", row_addr, e[11:0]);
      end
    end
  end

  task automatic normal_cycle(input logic [11:0] row, input logic wr, input logic oe, input bit keep_cas);
    addr = row; tick();
    ras_n = 1'b0; tick(2);
    addr = 12'h155; tick();
    we_n = wr; oe_n = oe; cas_n = 1'b0; tick(2);
    @(negedge clk);
    check(dq_oe == (wr & ~oe), "R8 drive in access", dq_oe, wr & ~oe);
    tick();
    expect_cls(2'b00, row);
    ras_n = 1'b1;
    if (!keep_cas) cas_n = 1'b1;
    tick(3);
    we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic ronly_cycle(input logic [11:0] row);
    addr = row; tick();
    ras_n = 1'b0; oe_n = 1'b0; tick(3);
    @(negedge clk);
    check(dq_oe == 1'b0, "R7 row-only quiet", dq_oe, 0);
    tick();
    expect_cls(2'b01, row);
    ras_n = 1'b1; oe_n = 1'b1; tick(3);
  endtask

  task automatic cbr_cycle(input bit probe);
    cas_n = 1'b0; tick();
    ras_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 12'hABC; tick(2);
    if (probe) begin
      @(negedge clk);
      check(dq_oe == 1'b0, "R7 CBR quiet", dq_oe, 0);
      check(row_addr == 12'(model_cnt), "R5 CBR row", row_addr, model_cnt);
      tick();
    end
    expect_cls(2'b10, 12'(model_cnt));
    model_cnt = (model_cnt + 1) % 4096;
    ras_n = 1'b1; tick();
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(2);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    tick(3);
    @(negedge clk);
    check(cls_pulse == 0 && row_act == 0 && dq_oe == 0 && hold_data == 0,
          "R12 reset outputs", {cls_pulse, row_act, dq_oe, hold_data}, 0);
    rst_n = 1'b1; tick(2);

    // R1, R4, R8: read with OE low, read with OE high, write
    normal_cycle(12'hFFF, 1'b1, 1'b0, 0);
    normal_cycle(12'h123, 1'b1, 1'b1, 0);
    normal_cycle(12'h800, 1'b0, 1'b0, 0);
    // R1, R7: row-only refresh
    ronly_cycle(12'h456);
    // R2, R5, R6: counter starts at 0 and is untouched by the above
    cbr_cycle(1);
    cbr_cycle(1);
    ronly_cycle(12'h001);
    normal_cycle(12'h777, 1'b1, 1'b0, 0);
    cbr_cycle(1);

    // R10: column transparency and latch
    @(negedge clk);
    check(col_addr == 12'h000, "R10 col idle", col_addr, 0);
    addr = 12'h321; tick();
    ras_n = 1'b0; tick();
    addr = 12'hFAB;
    @(negedge clk);
    check(col_addr == 12'h3AB, "R10 col follows", col_addr, 12'h3AB);
    tick();
    addr = 12'h0CD; tick();
    cas_n = 1'b0; tick();
    addr = 12'h0EE; tick();
    @(negedge clk);
    check(col_addr == 12'h0CD, "R10 col latched", col_addr, 12'h0CD);
    tick();
    expect_cls(2'b00, 12'h321);
    ras_n = 1'b1; cas_n = 1'b1; tick(3);

    // R9, R3: read then hidden refresh
    normal_cycle(12'h0AA, 1'b1, 1'b0, 1);
    @(negedge clk);
    check(hold_data == 1 && dq_oe == 1, "R9 hold after read", {hold_data, dq_oe}, 3);
    tick();
    ras_n = 1'b0; oe_n = 1'b1; tick(3);
    @(negedge clk);
    check(dq_oe == 1, "R9 drive in hidden", dq_oe, 1);
    check(row_addr == 12'(model_cnt), "R5 hidden row", row_addr, model_cnt);
    tick();
    expect_cls(2'b11, 12'(model_cnt));
    model_cnt = (model_cnt + 1) % 4096;
    ras_n = 1'b1; tick(2);
    cas_n = 1'b1; tick(2);
    @(negedge clk);
    check(hold_data == 0 && dq_oe == 0, "R9 release", {hold_data, dq_oe}, 0);
    tick();

    // R6: run the counter to the last row and across the wrap
    while (model_cnt != 4095) cbr_cycle(0);
    cbr_cycle(1);
    check(model_cnt == 0, "R6 model wrap", model_cnt, 0);
    cbr_cycle(1);

    tick(4);
    check(exp_q.size() == 0, "R11 all pulses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule